// File: doc/BRIEF.md
# Registered Parity Checker with Latched Error Flag

This block checks the parity of the command/address word that a registered buffer captures. On every rising clock edge it samples a 14-bit data word and the state of two active-low chip selects. The matching parity bit arrives later, one or two edges after its word, and a static configuration input sets which. When the parity bit arrives, the block XORs it with the covered bits of the stored word. It registers the result as the parity output, and an active-low error flag follows as the inverse of that result.

Once the error flag goes low, it stays low through at least two further clock edges, whatever later checks report. A new error during that window starts the window again. When both chip selects were high in the cycle a word was captured, that word is never checked and both outputs keep their values. A synchronous active-high reset clears the pipeline and the hold window. While reset is high, the outputs show the standby values straight away: parity low, error flag high.

Top module: `regbuf_parity_check`

## Requirements
- R1: After a check, `par_o` equals the XOR of the covered bits of the checked word with the parity bit used. For an even count of covered ones it is low when that parity bit is 0 and high when it is 1. For an odd count it is high when that parity bit is 0 and low when it is 1.
- R2: A check that gives `par_o` high drives `err_n_o` low. A check that gives `par_o` low drives `err_n_o` high, unless the hold window of R9 is still running.
- R3: With `lat2_i` = 0, the parity bit sampled at an edge is checked against the word sampled at the edge just before it.
- R4: With `lat2_i` = 1, the parity bit sampled at an edge is checked against the word sampled two edges before it.
- R5: A word captured while `cs_a_n` and `cs_b_n` are both high is not checked. On the edge where its check would have occurred, `par_o` and `err_n_o` keep their previous values.
- R6: A word captured while either chip select is low (`cs_a_n` alone low, or `cs_b_n` alone low) is checked.
- R7: While `rst` is high, `par_o` is 0 and `err_n_o` is 1. This holds in the same cycle `rst` rises and does not depend on the clock, the chip selects, the data or the parity bit.
- R8: Data bits whose position is set in `EXCLUDE_MASK` (by default bits 1 and 4) do not affect `par_o` or `err_n_o`.
- R9: After the edge that drives `err_n_o` low, `err_n_o` stays low after the next two edges, even if those edges check clean words.
- R10: An error detected while the R9 window is running restarts the window, so `err_n_o` stays low after the two edges that follow the new error.
- R11: After reset is released, no check happens on an edge whose selected pipeline slot holds no word captured since the release. The outputs keep their standby values on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every sample is taken on its rising edge |
| rst | input | 1 | Synchronous active-high reset; it also forces the outputs to standby values while high |
| cs_a_n | input | 1 | First chip select, active low |
| cs_b_n | input | 1 | Second chip select, active low |
| data_i | input | 14 | Command/address word sampled on each edge |
| par_i | input | 1 | Parity bit for the word captured one or two edges earlier |
| lat2_i | input | 1 | Parity latency select: 0 means one edge, 1 means two edges; static outside reset |
| par_o | output | 1 | Registered parity result |
| err_n_o | output | 1 | Active-low parity error flag with a minimum hold time |

## Verification
The bench concentrates on the alignment between each parity bit and its word at both latency settings. A design that pairs the wrong word shows mismatches as soon as consecutive words have different parities. It gates a check on the chip selects from the capture cycle rather than the check cycle. It also covers the first edges after reset, where a design that checks stale pipeline contents raises false errors. The error hold is exercised with clean words right after an error, and again with a second error inside the window. A counter that never restarts, or a hold that is one edge too short, releases the flag early. Words that differ only in the excluded bits, and reset raised in the middle of a running hold, expose a wrong mask and a reset that waits for the clock.

// File: rtl/regbuf_parity_pkg.sv
package regbuf_parity_pkg;

    localparam int DATA_W = 14;

    // One captured word together with its chip-select qualification
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] word;
    } cap_t;

    // Outcome of evaluating the aligned slot against the incoming parity bit
    typedef struct packed {
        logic check;
        logic parity;
    } eval_t;

    function automatic logic covered_xor(input logic [DATA_W-1:0] w,
                                         input logic [DATA_W-1:0] excl);
        return ^(w & ~excl);
    endfunction

endpackage

// File: rtl/regbuf_parity_align.sv
module regbuf_parity_align
    import regbuf_parity_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] data_i,
    input  logic              lat2_i,
    output cap_t              slot_o
);

    cap_t stage [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            stage[0] <= '0;
        end else begin
            stage[0] <= '{valid: cap_en, word: data_i};
        end
    end

    for (genvar s = 1; s < DEPTH; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stage[s] <= '0;
            end else begin
                stage[s] <= stage[s-1];
            end
        end
    end

    assign slot_o = lat2_i ? stage[DEPTH-1] : stage[0];

endmodule

// File: rtl/regbuf_parity_eval.sv
module regbuf_parity_eval
    import regbuf_parity_pkg::*;
#(
    parameter logic [DATA_W-1:0] EXCLUDE_MASK = 14'h0012
) (
    input  cap_t  slot_i,
    input  logic  par_i,
    output eval_t res_o
);

    always_comb begin
        res_o.check  = slot_i.valid;
        res_o.parity = covered_xor(slot_i.word, EXCLUDE_MASK) ^ par_i;
    end

endmodule

// File: rtl/regbuf_parity_hold.sv
module regbuf_parity_hold
    import regbuf_parity_pkg::*;
#(
    parameter int HOLD_CYCLES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  eval_t res_i,
    output logic  par_q,
    output logic  err_nq
);

    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);

    logic [CNT_W-1:0] hold_cnt;
    logic             holding;

    assign holding = (hold_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            par_q    <= 1'b0;
            err_nq   <= 1'b1;
            hold_cnt <= '0;
        end else if (res_i.check && res_i.parity) begin
            par_q    <= 1'b1;
            err_nq   <= 1'b0;
            hold_cnt <= CNT_W'(HOLD_CYCLES);
        end else begin
            if (res_i.check) begin
                par_q <= 1'b0;
                if (!holding) begin
                    err_nq <= 1'b1;
                end
            end
            if (holding) begin
                hold_cnt <= hold_cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/regbuf_parity_check.sv
module regbuf_parity_check
    import regbuf_parity_pkg::*;
#(
    parameter logic [DATA_W-1:0] EXCLUDE_MASK = 14'h0012,
    parameter int                HOLD_CYCLES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_a_n,
    input  logic              cs_b_n,
    input  logic [DATA_W-1:0] data_i,
    input  logic              par_i,
    input  logic              lat2_i,
    output logic              par_o,
    output logic              err_n_o
);

    cap_t  slot;
    eval_t res;
    logic  cap_en;
    logic  par_q;
    logic  err_nq;

    assign cap_en = !(cs_a_n && cs_b_n);

    regbuf_parity_align #(
        .DEPTH (2)
    ) u_align (
        .clk    (clk),
        .rst    (rst),
        .cap_en (cap_en),
        .data_i (data_i),
        .lat2_i (lat2_i),
        .slot_o (slot)
    );

    regbuf_parity_eval #(
        .EXCLUDE_MASK (EXCLUDE_MASK)
    ) u_eval (
        .slot_i (slot),
        .par_i  (par_i),
        .res_o  (res)
    );

    regbuf_parity_hold #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_hold (
        .clk    (clk),
        .rst    (rst),
        .res_i  (res),
        .par_q  (par_q),
        .err_nq (err_nq)
    );

    // Standby values appear as soon as reset is raised, before any edge
    assign par_o   = rst ? 1'b0 : par_q;
    assign err_n_o = rst ? 1'b1 : err_nq;

endmodule

// File: rtl/regbuf_parity_check_sva.sv
module regbuf_parity_check_sva (
    input logic clk,
    input logic rst,
    input logic cs_a_n,
    input logic cs_b_n,
    input logic lat2_i,
    input logic par_o,
    input logic err_n_o
);

    // R7: standby values while reset is high
    a_r7_reset_outputs: assert property (@(posedge clk)
        rst |-> (!par_o && err_n_o));

    // R9: the error flag stays low through the next two edges
    a_r9_error_hold: assert property (@(posedge clk) disable iff (rst)
        $fell(err_n_o) |=> !err_n_o ##1 !err_n_o);

    // R2: the flag only falls on a check that yields parity high
    a_r2_fall_with_parity: assert property (@(posedge clk) disable iff (rst)
        $fell(err_n_o) |-> par_o);

    // R2: the flag only releases on a clean check
    a_r2_release_clean: assert property (@(posedge clk) disable iff (rst)
        $rose(err_n_o) |-> !par_o);

    // R5: an unselected capture at latency one leaves both outputs unchanged
    a_r5_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!lat2_i && cs_a_n && cs_b_n) |=> ##1 ($stable(par_o) && $stable(err_n_o)));

endmodule

bind regbuf_parity_check regbuf_parity_check_sva u_sva (
    .clk     (clk),
    .rst     (rst),
    .cs_a_n  (cs_a_n),
    .cs_b_n  (cs_b_n),
    .lat2_i  (lat2_i),
    .par_o   (par_o),
    .err_n_o (err_n_o)
);

// File: tb/regbuf_parity_check_bench.sv
module regbuf_parity_check_bench;

    localparam int          CLK_PERIOD = 10;
    localparam logic [13:0] EXCL       = 14'h0012;

    logic        clk    = 1'b0;
    logic        rst    = 1'b1;
    logic        cs_a_n = 1'b1;
    logic        cs_b_n = 1'b1;
    logic [13:0] data   = '0;
    logic        par_in = 1'b0;
    logic        lat2   = 1'b0;
    logic        par_o;
    logic        err_n_o;

    int checks = 0;
    int errors = 0;

    // Behavioural reference state
    bit [14:0] hist [$];   // {selected, word}, most recent first
    bit        m_par  = 1'b0;
    bit        m_errn = 1'b1;
    int        m_hold = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regbuf_parity_check u_regbuf_parity_check (
        .clk     (clk),
        .rst     (rst),
        .cs_a_n  (cs_a_n),
        .cs_b_n  (cs_b_n),
        .data_i  (data),
        .par_i   (par_in),
        .lat2_i  (lat2),
        .par_o   (par_o),
        .err_n_o (err_n_o)
    );

    function automatic bit ones_odd(input bit [13:0] w);
        int n = 0;
        for (int i = 0; i < 14; i++) begin
            if (!EXCL[i] && w[i]) n++;
        end
        return (n % 2) == 1;
    endfunction

    task automatic check(input string tag, input string what, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        int idx;
        bit p;
        if (rst) begin
            hist.delete();
            m_par  = 1'b0;
            m_errn = 1'b1;
            m_hold = 0;
        end else begin
            idx = lat2 ? 1 : 0;
            if (hist.size() > idx && hist[idx][14]) begin
                p = ones_odd(hist[idx][13:0]) ^ par_in;
                m_par = p;
                if (p) begin
                    m_errn = 1'b0;
                    m_hold = 2;
                end else if (m_hold > 0) begin
                    m_hold--;
                end else begin
                    m_errn = 1'b1;
                end
            end else if (m_hold > 0) begin
                m_hold--;
            end
            hist.push_front({!(cs_a_n && cs_b_n), data});
            if (hist.size() > 2) void'(hist.pop_back());
        end
    endtask

    task automatic cyc(input string tag, input bit [13:0] d, input bit p,
                       input bit a, input bit b, input bit r);
        data   = d;
        par_in = p;
        cs_a_n = a;
        cs_b_n = b;
        rst    = r;
        @(posedge clk);
        @(negedge clk);
        model_edge();
        check(tag, "par_o", par_o, rst ? 1'b0 : m_par);
        check(tag, "err_n_o", err_n_o, rst ? 1'b1 : m_errn);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R7: reset state with busy inputs
        cyc("R7", 14'h3FFF, 1'b1, 1'b0, 1'b0, 1'b1);
        cyc("R7", 14'h0001, 1'b0, 1'b0, 1'b1, 1'b1);
        check("R7", "par_o reset", par_o, 1'b0);
        check("R7", "err_n_o reset", err_n_o, 1'b1);

        // R11: first edge after release has nothing captured yet
        cyc("R11", 14'h0001, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R11", "par_o standby", par_o, 1'b0);
        check("R11", "err_n_o standby", err_n_o, 1'b1);

        // R1 R3: four parity combinations at latency one
        cyc("R1", 14'h0003, 1'b0, 1'b0, 1'b0, 1'b0); // checks 0x0001 with 0 -> odd,0 -> high
        check("R1", "odd,par0", par_o, 1'b1);
        cyc("R9", 14'h0000, 1'b0, 1'b0, 1'b0, 1'b0); // 0x0003 (bit1 excluded) odd,0 -> high
        cyc("R9", 14'h0000, 1'b0, 1'b0, 1'b0, 1'b0); // even,0 -> low, flag held
        check("R9", "hold edge 1", err_n_o, 1'b0);
        cyc("R9", 14'h0000, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R9", "hold edge 2", err_n_o, 1'b0);
        cyc("R2", 14'h0005, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R2", "released", err_n_o, 1'b1);
        cyc("R3", 14'h0000, 1'b0, 1'b0, 1'b0, 1'b0); // 0x0005 even,0 -> low
        check("R1", "even,par0", par_o, 1'b0);
        cyc("R3", 14'h0000, 1'b1, 1'b0, 1'b0, 1'b0); // even,1 -> high
        check("R1", "even,par1", par_o, 1'b1);
        cyc("R10", 14'h0001, 1'b0, 1'b0, 1'b0, 1'b0);
        cyc("R10", 14'h0000, 1'b1, 1'b0, 1'b0, 1'b0); // odd,1 -> low
        check("R1", "odd,par1", par_o, 1'b0);
        cyc("R10", 14'h0000, 1'b1, 1'b0, 1'b0, 1'b0); // new error during hold
        cyc("R10", 14'h0000, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R10", "restart edge 1", err_n_o, 1'b0);
        cyc("R10", 14'h0000, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R10", "restart edge 2", err_n_o, 1'b0);
        cyc("R10", 14'h0000, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R10", "restart release", err_n_o, 1'b1);

        // R8: excluded bits alone never raise an error
        cyc("R8", 14'h0002, 1'b0, 1'b0, 1'b0, 1'b0);
        cyc("R8", 14'h0010, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R8", "bit1 excluded", par_o, 1'b0);
        cyc("R8", 14'h0012, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R8", "bit4 excluded", par_o, 1'b0);
        cyc("R8", 14'h0000, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R8", "bits1,4 excluded", err_n_o, 1'b1);

        // R5: unselected capture, odd word with parity 0 would flag
        cyc("R5", 14'h0001, 1'b0, 1'b1, 1'b1, 1'b0);
        cyc("R5", 14'h0000, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R5", "no check par", par_o, 1'b0);
        check("R5", "no check err", err_n_o, 1'b1);
        // R6: each chip select alone qualifies a capture
        cyc("R6", 14'h0001, 1'b0, 1'b0, 1'b1, 1'b0);
        cyc("R6", 14'h0000, 1'b1, 1'b1, 1'b0, 1'b0); // odd,1 -> low
        cyc("R6", 14'h0000, 1'b1, 1'b1, 1'b1, 1'b0); // even,1 -> high, cs_b_n alone
        check("R6", "cs_b_n only", par_o, 1'b1);
        check("R6", "cs_b_n only err", err_n_o, 1'b0);

        // R7: reset in the middle of a hold window forces standby at once
        data = 14'h0001; par_in = 1'b0; rst = 1'b1;
        #1;
        check("R7", "par_o async view", par_o, 1'b0);
        check("R7", "err_n_o async view", err_n_o, 1'b1);
        lat2 = 1'b1;
        cyc("R7", 14'h0001, 1'b0, 1'b0, 1'b0, 1'b1);

        // R4 R11: latency two
        cyc("R11", 14'h0001, 1'b0, 1'b0, 1'b0, 1'b0);
        cyc("R11", 14'h0000, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R11", "slot two empty", err_n_o, 1'b1);
        cyc("R4", 14'h0000, 1'b1, 1'b0, 1'b0, 1'b0); // 0x0001 odd,1 -> low
        check("R4", "two-edge pairing", par_o, 1'b0);
        cyc("R4", 14'h0000, 1'b0, 1'b0, 1'b0, 1'b0); // 0x0000 even,0 -> low
        check("R4", "two-edge pairing err", err_n_o, 1'b1);
        for (int i = 0; i < 300; i++) begin
            cyc("R4", 14'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'b0);
        end

        // Random traffic at latency one
        lat2 = 1'b0;
        cyc("R7", 14'h0000, 1'b0, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 300; i++) begin
            cyc("R3", 14'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                ($urandom % 40) == 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule